// File: doc/BRIEF.md
# Destination address filter

This block decides, once per received frame, whether the frame is kept or dropped. It looks at the frame's 48-bit destination address, its byte length and an error flag from the receive path. It also uses a programmed 48-bit node address, a 64-bit multicast hash table and five enable bits. When the receive path pulses `frame_end`, the block judges the frame. One clock later it returns a one-cycle verdict together with three class flags (physical, multicast, broadcast) that the receive path writes into the frame's status word.

The address is classified first. The all-ones address is broadcast. Any other address whose first byte has bit 0 set is multicast. Everything else is physical. Each class has its own acceptance rule. Multicast frames are looked up in the hash table: a CRC-32 is run over the address and 6 of its bits select one table bit. A frame is kept only when it passes the address rule, the length rule and the error rule together.

Top module: `rx_addr_filter`

## Requirements
- R1: The address is classified as follows, with the first byte at `dest_addr[7:0]`. `dest_addr` equal to all ones is broadcast (`cls_bcast`). Otherwise, `dest_addr[0]`=1 is multicast (`cls_mcast`). Otherwise the address is physical (`cls_phys`). With `verdict_valid` high, exactly one of the three flags is high. The flags keep their value until the next `frame_end`.
- R2: A physical frame passes the address rule when `cfg_promisc`=1, or when `dest_addr` equals `node_addr`.
- R3: A broadcast frame passes the address rule only when `cfg_bcast`=1.
- R4: A multicast frame passes the address rule only when `cfg_mcast`=1 and `hash_tbl[idx]`=1. The index `idx` comes from a CRC-32 run as follows:
  - The register starts at all ones.
  - The reflected polynomial 0xEDB88320 is used.
  - The address bits are fed from `dest_addr[0]` up to `dest_addr[47]`. For each bit, the feedback is crc[0] xor the address bit; the register is shifted right by one, then xored with the polynomial if the feedback is 1.
  - No final inversion is applied.
  - `idx` is register bits [31:26] of the result.
- R5: A frame with `frame_len` below 64 is kept only when `cfg_runt`=1. A length of exactly 64 is never treated as short.
- R6: A frame with `rx_err`=1 is kept only when `cfg_err`=1.
- R7: `verdict_keep` is high only when the address rule, the length rule and the error rule all pass in the same frame.
- R8: These rules govern the verdict timing and reset state:
  - `verdict_valid` is high for exactly the one cycle after each cycle in which `frame_end` is high.
  - `verdict_keep` is low whenever `verdict_valid` is low.
  - After reset, all outputs are 0.
- R9: `cfg_promisc` has no effect on broadcast or multicast frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_end | input | 1 | One-cycle strobe: the frame's inputs are valid, so judge it |
| dest_addr | input | 48 | Destination address, first byte in bits [7:0] |
| frame_len | input | 14 | Frame length in bytes |
| rx_err | input | 1 | Frame was received with an error |
| node_addr | input | 48 | Programmed station address |
| hash_tbl | input | 64 | Multicast hash table |
| cfg_promisc | input | 1 | Accept any physical address |
| cfg_bcast | input | 1 | Accept broadcast |
| cfg_mcast | input | 1 | Accept multicast that hits the hash table |
| cfg_runt | input | 1 | Accept frames shorter than 64 bytes |
| cfg_err | input | 1 | Accept frames with errors |
| verdict_valid | output | 1 | Verdict strobe, one cycle after `frame_end` |
| verdict_keep | output | 1 | Frame is accepted |
| cls_phys | output | 1 | Physical-address frame |
| cls_mcast | output | 1 | Multicast frame |
| cls_bcast | output | 1 | Broadcast frame |

## Verification
The address rule and the length/error rules are evaluated in the same `frame_end` cycle. So a single frame can pass one rule and fail another, for example a matching physical address that is also a runt with an error. The bench sends such frames with only some of the enables set and expects a reject with the class flag still reported. It also sends the all-ones address, where the broadcast and multicast tests overlap because bit 0 is set. Here the bench expects only `cls_bcast` and expects the broadcast enable, not the hash table, to decide.

// File: rtl/rx_filt_pkg.sv
package rx_filt_pkg;
  localparam int unsigned ADDR_W   = 48;
  localparam int unsigned CRC_W    = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB8_8320;
  localparam logic [CRC_W-1:0] CRC_SEED = 32'hFFFF_FFFF;

  typedef struct packed {
    logic bcast;
    logic mcast;
    logic phys;
  } addr_cls_t;
endpackage

// File: rtl/rx_filt_rst_sync.sv
module rx_filt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/rx_filt_class.sv
module rx_filt_class
  import rx_filt_pkg::*;
(
  input  logic [ADDR_W-1:0] dest_addr,
  input  logic [ADDR_W-1:0] node_addr,
  output addr_cls_t         cls,
  output logic              node_hit
);
  logic all_ones;

  always_comb begin
    all_ones  = &dest_addr;
    cls.bcast = all_ones;
    cls.mcast = dest_addr[0] & ~all_ones;
    cls.phys  = ~dest_addr[0];
    node_hit  = (dest_addr == node_addr);
  end
endmodule

// File: rtl/rx_filt_hash.sv
module rx_filt_hash
  import rx_filt_pkg::*;
#(
  parameter int unsigned HASH_W = 6,
  localparam int unsigned TBL_N = 1 << HASH_W
) (
  input  logic [ADDR_W-1:0] dest_addr,
  input  logic [TBL_N-1:0]  hash_tbl,
  output logic              hash_hit
);
  logic [CRC_W-1:0] crc_chain [0:ADDR_W];
  logic [HASH_W-1:0] idx;

  assign crc_chain[0] = CRC_SEED;

  for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
    logic fb;
    assign fb = crc_chain[i][0] ^ dest_addr[i];
    assign crc_chain[i+1] = (crc_chain[i] >> 1) ^ (fb ? CRC_POLY : '0);
  end

  assign idx      = crc_chain[ADDR_W][CRC_W-1 -: HASH_W];
  assign hash_hit = hash_tbl[idx];
endmodule

// File: rtl/rx_filt_decide.sv
module rx_filt_decide
  import rx_filt_pkg::*;
#(
  parameter int unsigned LEN_W   = 14,
  parameter int unsigned MIN_LEN = 64
) (
  input  addr_cls_t        cls,
  input  logic             node_hit,
  input  logic             hash_hit,
  input  logic [LEN_W-1:0] frame_len,
  input  logic             rx_err,
  input  logic             cfg_promisc,
  input  logic             cfg_bcast,
  input  logic             cfg_mcast,
  input  logic             cfg_runt,
  input  logic             cfg_err,
  output logic             keep
);
  localparam logic [LEN_W-1:0] MIN_LEN_V = LEN_W'(MIN_LEN);

  logic addr_ok, len_ok, err_ok;

  always_comb begin
    unique case (1'b1)
      cls.bcast: addr_ok = cfg_bcast;
      cls.mcast: addr_ok = cfg_mcast & hash_hit;
      default:   addr_ok = cfg_promisc | node_hit;
    endcase
    len_ok = (frame_len >= MIN_LEN_V) | cfg_runt;
    err_ok = ~rx_err | cfg_err;
    keep   = addr_ok & len_ok & err_ok;
  end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rx_filt_pkg::*;
#(
  parameter int unsigned LEN_W   = 14,
  parameter int unsigned MIN_LEN = 64,
  parameter int unsigned HASH_W  = 6,
  localparam int unsigned TBL_N  = 1 << HASH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_end,
  input  logic [ADDR_W-1:0] dest_addr,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic              rx_err,
  input  logic [ADDR_W-1:0] node_addr,
  input  logic [TBL_N-1:0]  hash_tbl,
  input  logic              cfg_promisc,
  input  logic              cfg_bcast,
  input  logic              cfg_mcast,
  input  logic              cfg_runt,
  input  logic              cfg_err,
  output logic              verdict_valid,
  output logic              verdict_keep,
  output logic              cls_phys,
  output logic              cls_mcast,
  output logic              cls_bcast
);
  localparam logic [LEN_W-1:0] MIN_LEN_V = LEN_W'(MIN_LEN);

  logic      rst_n_i;
  addr_cls_t cls_d, cls_q;
  logic      node_hit, hash_hit, keep_d;
  logic      valid_q, keep_q;
  logic      valid_n, keep_n;
  addr_cls_t cls_n;

  rx_filt_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  rx_filt_class u_class (
    .dest_addr(dest_addr), .node_addr(node_addr),
    .cls(cls_d), .node_hit(node_hit)
  );

  rx_filt_hash #(.HASH_W(HASH_W)) u_hash (
    .dest_addr(dest_addr), .hash_tbl(hash_tbl), .hash_hit(hash_hit)
  );

  rx_filt_decide #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_decide (
    .cls(cls_d), .node_hit(node_hit), .hash_hit(hash_hit),
    .frame_len(frame_len), .rx_err(rx_err),
    .cfg_promisc(cfg_promisc), .cfg_bcast(cfg_bcast), .cfg_mcast(cfg_mcast),
    .cfg_runt(cfg_runt), .cfg_err(cfg_err), .keep(keep_d)
  );

  // next state
  always_comb begin
    valid_n = frame_end;
    keep_n  = frame_end & keep_d;
    cls_n   = frame_end ? cls_d : cls_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      valid_q <= 1'b0;
      keep_q  <= 1'b0;
      cls_q   <= '0;
    end else begin
      valid_q <= valid_n;
      keep_q  <= keep_n;
      cls_q   <= cls_n;
    end
  end

  assign verdict_valid = valid_q;
  assign verdict_keep  = keep_q;
  assign cls_phys      = cls_q.phys;
  assign cls_mcast     = cls_q.mcast;
  assign cls_bcast     = cls_q.bcast;

  // R8
  valid_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    frame_end |=> verdict_valid);
  // R8
  valid_needs_end_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    verdict_valid |-> $past(frame_end));
  // R8
  keep_gated_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    !verdict_valid |-> !verdict_keep);
  // R1
  one_class_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    verdict_valid |-> $countones({cls_phys, cls_mcast, cls_bcast}) == 1);
  // R1
  class_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    !frame_end |=> $stable({cls_phys, cls_mcast, cls_bcast}));
  // R3
  bcast_enable_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (verdict_keep && cls_bcast) |-> $past(cfg_bcast));
  // R4
  mcast_enable_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (verdict_keep && cls_mcast) |-> $past(cfg_mcast));
  // R5
  runt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    verdict_keep |-> $past((frame_len >= MIN_LEN_V) || cfg_runt));
  // R6
  err_gate_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    verdict_keep |-> $past(!rx_err || cfg_err));
endmodule

// File: tb/rx_addr_filter_bench.sv
module rx_addr_filter_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_end;
  logic [47:0] dest_addr;
  logic [13:0] frame_len;
  logic        rx_err;
  logic [47:0] node_addr;
  logic [63:0] hash_tbl;
  logic        cfg_promisc, cfg_bcast, cfg_mcast, cfg_runt, cfg_err;
  logic        verdict_valid, verdict_keep, cls_phys, cls_mcast, cls_bcast;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  localparam logic [47:0] NODE  = 48'h5544_3322_1100;
  localparam logic [47:0] OTHER = 48'h5544_3322_1102;
  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] MC_A  = 48'h0100_005E_0001;
  localparam logic [47:0] MC_B  = 48'h3300_0000_0033;

  always #10 clk = ~clk;

  rx_addr_filter u_rx_addr_filter (
    .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .dest_addr(dest_addr),
    .frame_len(frame_len), .rx_err(rx_err), .node_addr(node_addr),
    .hash_tbl(hash_tbl), .cfg_promisc(cfg_promisc), .cfg_bcast(cfg_bcast),
    .cfg_mcast(cfg_mcast), .cfg_runt(cfg_runt), .cfg_err(cfg_err),
    .verdict_valid(verdict_valid), .verdict_keep(verdict_keep),
    .cls_phys(cls_phys), .cls_mcast(cls_mcast), .cls_bcast(cls_bcast)
  );

  function automatic logic [5:0] ref_idx(input logic [47:0] a);
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < 48; i++) begin
      logic fb;
      fb = c[0] ^ a[i];
      c  = c >> 1;
      if (fb) c = c ^ 32'hEDB8_8320;
    end
    return c[31:26];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic p, input logic b, input logic m,
                         input logic r, input logic e);
    cfg_promisc = p; cfg_bcast = b; cfg_mcast = m; cfg_runt = r; cfg_err = e;
  endtask

  // drive one frame, sample verdict in the cycle after frame_end
  task automatic send(input string req, input logic [47:0] da, input logic [13:0] len,
                      input logic err, input logic exp_keep, input logic [2:0] exp_cls);
    @(negedge clk);
    dest_addr = da; frame_len = len; rx_err = err; frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
    check({req, " valid"}, 32'(verdict_valid), 32'd1);
    check({req, " keep"}, 32'(verdict_keep), 32'(exp_keep));
    check({req, " class b/m/p"}, 32'({cls_bcast, cls_mcast, cls_phys}), 32'(exp_cls));
  endtask

  task automatic t_reset;
    check("R8 reset valid", 32'(verdict_valid), 32'd0);
    check("R8 reset keep", 32'(verdict_keep), 32'd0);
    check("R8 reset class", 32'({cls_bcast, cls_mcast, cls_phys}), 32'd0);
  endtask

  task automatic t_phys;
    set_cfg(0, 1, 1, 0, 0);
    send("R2 node match", NODE, 14'd100, 0, 1, 3'b001);
    send("R2 node mismatch", OTHER, 14'd100, 0, 0, 3'b001);
    set_cfg(1, 0, 0, 0, 0);
    send("R2 promisc mismatch", OTHER, 14'd100, 0, 1, 3'b001);
  endtask

  task automatic t_bcast;
    set_cfg(0, 1, 0, 0, 0);
    hash_tbl = '1;
    send("R3 bcast enabled", BCAST, 14'd64, 0, 1, 3'b100);
    set_cfg(0, 0, 1, 0, 0);
    send("R3 bcast disabled, mcast on", BCAST, 14'd64, 0, 0, 3'b100);
    set_cfg(1, 0, 0, 0, 0);
    send("R9 promisc no bcast", BCAST, 14'd64, 0, 0, 3'b100);
  endtask

  task automatic t_mcast;
    set_cfg(0, 0, 1, 0, 0);
    hash_tbl = 64'd1 << ref_idx(MC_A);
    send("R4 hash hit A", MC_A, 14'd80, 0, 1, 3'b010);
    hash_tbl = ~(64'd1 << ref_idx(MC_A));
    send("R4 hash miss A", MC_A, 14'd80, 0, 0, 3'b010);
    hash_tbl = 64'd1 << ref_idx(MC_B);
    send("R4 hash hit B", MC_B, 14'd80, 0, 1, 3'b010);
    hash_tbl = '1;
    set_cfg(0, 1, 0, 0, 0);
    send("R4 mcast disabled", MC_B, 14'd80, 0, 0, 3'b010);
    set_cfg(1, 1, 0, 0, 0);
    send("R9 promisc no mcast", MC_A, 14'd80, 0, 0, 3'b010);
  endtask

  task automatic t_runt;
    set_cfg(0, 0, 0, 0, 0);
    send("R5 len 63 rejected", NODE, 14'd63, 0, 0, 3'b001);
    send("R5 len 64 kept", NODE, 14'd64, 0, 1, 3'b001);
    set_cfg(0, 0, 0, 1, 0);
    send("R5 len 63 runt on", NODE, 14'd63, 0, 1, 3'b001);
  endtask

  task automatic t_err;
    set_cfg(0, 0, 0, 0, 0);
    send("R6 error rejected", NODE, 14'd200, 1, 0, 3'b001);
    set_cfg(0, 0, 0, 0, 1);
    send("R6 error accepted", NODE, 14'd200, 1, 1, 3'b001);
  endtask

  task automatic t_combo;
    set_cfg(0, 0, 0, 1, 0);
    send("R7 runt ok, error blocks", NODE, 14'd20, 1, 0, 3'b001);
    set_cfg(0, 0, 0, 1, 1);
    send("R7 runt+error both on", NODE, 14'd20, 1, 1, 3'b001);
    send("R7 address fails", OTHER, 14'd20, 1, 0, 3'b001);
    set_cfg(0, 1, 0, 0, 1);
    send("R7 bcast ok, runt blocks", BCAST, 14'd10, 1, 0, 3'b100);
  endtask

  task automatic t_timing;
    set_cfg(0, 1, 0, 0, 0);
    send("R8 pulse", BCAST, 14'd64, 0, 1, 3'b100);
    dest_addr = NODE;
    @(negedge clk);
    check("R8 valid one cycle", 32'(verdict_valid), 32'd0);
    check("R8 keep low without valid", 32'(verdict_keep), 32'd0);
    check("R1 class held", 32'({cls_bcast, cls_mcast, cls_phys}), 32'b100);
  endtask

  initial begin
    frame_end = 0; dest_addr = '0; frame_len = '0; rx_err = 0;
    node_addr = NODE; hash_tbl = '0;
    set_cfg(0, 0, 0, 0, 0);
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset;
    t_phys;
    t_bcast;
    t_mcast;
    t_runt;
    t_err;
    t_combo;
    t_timing;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule